// File: doc/BRIEF.md
# Input Overvoltage Fault Supervisor

This block watches a digitized input-voltage sample. It compares that sample with a programmable 4-bit overvoltage threshold, and it applies a fixed hysteresis on release. When a valid sample rises above the threshold, the block turns the power switch enable off. The enable comes back on by itself once a later valid sample falls below the threshold minus 250 mV.

A fault also sets sticky flags in five status bytes. These flags stay latched after the voltage recovers and until a clear-faults strobe arrives. While any flag is latched, an active-low alert line is driven, subject to mask inputs and a pin-function enable. A power-good output follows the live fault state when its pin is configured for that use.

The threshold code is loaded through a simple write port. A write takes effect only while the write-protect unlock input is high. The code reads back as a 16-bit word. The serial bus engine, the DAC and the analog comparator sit outside this block.

Top module: `ovp_supervisor`

## Requirements
- R1: After reset, `thr_word` reads 0x000E, `out_en` and `alert_n` and `pgood` are 1, and all five status bytes are 0.
- R2: A write with `wr_en` and `unlock` both high loads `wr_data[3:0]` as the threshold code from the next cycle. `thr_word` returns the code in bits 3:0, and bits 15:4 read 0.
- R3: A write with `unlock` low leaves the threshold code unchanged.
- R4: The rising threshold in mV is 2960 + code*984. A valid sample strictly greater than it clears `out_en` from the next cycle. A sample equal to it does not trip.
- R5: While tripped, `out_en` stays 0 for valid samples at or above the rising threshold minus 250 mV. It returns to 1 one cycle after a valid sample strictly below that level.
- R6: Samples presented with `vin_vld` low have no effect on `out_en` or on the flags.
- R7: Each cycle after a valid sample that leaves the block tripped, the status bytes read as follows. `st_byte` is 0x41 (bit 6 switch off, bit 0 other). `st_word_hi` is 0xA9 (bit 7 output, bit 5 input, bit 3 power-good bad, bit 0 other). `st_out` is 0x20 (bit 5 output undervoltage warning). `st_in` is 0x80 (bit 7 input overvoltage). `st_mfr` is 0x08 (bit 3 power-good bad).
- R8: The flags stay set after `out_en` recovers, until a cycle with `clr_faults` high. That cycle clears all flags on the next edge.
- R9: When a clear and a valid sample that leaves the block tripped arrive in the same cycle, the set wins. A clear while tripped is therefore undone by the next valid sample.
- R10: `alert_n` is 0 exactly when flags are latched, `alert_pin_en` is 1, and at least one of `mask_in`, `mask_pg`, `mask_out` is 0 (a mask bit of 1 suppresses its source).
- R11: `pgood` is 0 exactly when `pg_pin_en` is 1 and the block is tripped. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vin_mv | input | 16 | Input voltage sample in millivolts |
| vin_vld | input | 1 | Sample valid strobe |
| wr_en | input | 1 | Threshold register write strobe |
| wr_data | input | 16 | Threshold write word, code in bits 3:0 |
| unlock | input | 1 | Write-protect unlock level |
| clr_faults | input | 1 | Clear latched flags |
| mask_in | input | 1 | Suppress alert from input status |
| mask_pg | input | 1 | Suppress alert from power-good status |
| mask_out | input | 1 | Suppress alert from output status |
| alert_pin_en | input | 1 | Alert function enabled on its pin |
| pg_pin_en | input | 1 | Pin configured as power-good output |
| thr_word | output | 16 | Threshold register read word |
| out_en | output | 1 | Power switch enable |
| alert_n | output | 1 | Active-low alert |
| pgood | output | 1 | Power-good output |
| st_byte | output | 8 | Summary status byte |
| st_word_hi | output | 8 | Upper byte of status word |
| st_out | output | 8 | Output status |
| st_in | output | 8 | Input status |
| st_mfr | output | 8 | Manufacturer status |

## Verification
The checker tests the following on every cycle:
- a locked write never moves the threshold word, and an unlocked write lands on the next cycle;
- a sample above the decoded rising level always drops the enable;
- invalid samples leave the enable frozen;
- latched flags hold unless cleared;
- the alert and power-good pins respect their pin-function enables.

Other behaviour only the bench scenarios can show:
- the exact boundary at equality on both thresholds;
- the set-over-clear priority while the voltage sits inside the hysteresis band;
- the full mask combinations against a reference model under random voltage sweeps around moving thresholds.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    // One sticky bit per status category; all set by the same fault event
    typedef struct packed {
        logic sw_off;
        logic in_ov;
        logic out_uvw;
        logic pg_bad;
        logic other;
    } flag_t;

    localparam flag_t FLAGS_CLEAR = '{default: 1'b0};
    localparam flag_t FLAGS_FAULT = '{default: 1'b1};

endpackage

// File: rtl/ovp_thresh.sv
module ovp_thresh #(
    parameter int CODE_W   = 4,
    parameter int VW       = 16,
    parameter int BASE_MV  = 2960,
    parameter int STEP_MV  = 984,
    parameter int HYST_MV  = 250,
    parameter int RST_CODE = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              unlock,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_o,
    output logic [VW-1:0]     rise_mv,
    output logic [VW-1:0]     fall_mv
);
    localparam logic [CODE_W-1:0] RST_VAL = CODE_W'(RST_CODE);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } st_t;

    st_t st_d, st_q;
    int  rise_i;

    always_comb begin
        st_d = st_q;
        // write protection: only an unlocked write lands
        if (wr_en && unlock) begin
            st_d.code = wr_code;
        end
        rise_i  = BASE_MV + int'(st_q.code) * STEP_MV;
        rise_mv = VW'(rise_i);
        fall_mv = VW'(rise_i - HYST_MV);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;

endmodule

// File: rtl/ovp_detect.sv
module ovp_detect #(
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vin_mv,
    input  logic          vin_vld,
    input  logic [VW-1:0] rise_mv,
    input  logic [VW-1:0] fall_mv,
    output logic          trip_o,
    output logic          hit_o
);
    typedef struct packed {
        logic trip;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vin_vld) begin
            if (vin_mv > rise_mv) begin
                st_d.trip = 1'b1;
            end else if (vin_mv < fall_mv) begin
                st_d.trip = 1'b0;
            end
        end
        // a valid sample that leaves the block tripped (re)arms the flags
        hit_o = vin_vld && st_d.trip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.trip <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o = st_q.trip;

endmodule

// File: rtl/ovp_flags.sv
module ovp_flags
    import ovp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit,
    input  logic  clr,
    output flag_t flags_o
);
    typedef struct packed {
        flag_t f;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.f = FLAGS_FAULT;
        end else if (clr) begin
            st_d.f = FLAGS_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.f <= FLAGS_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.f;

endmodule

// File: rtl/ovp_supervisor.sv
module ovp_supervisor
    import ovp_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int VW       = 16,
    parameter int WORD_W   = 16,
    parameter int BASE_MV  = 2960,
    parameter int STEP_MV  = 984,
    parameter int HYST_MV  = 250,
    parameter int RST_CODE = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VW-1:0]     vin_mv,
    input  logic              vin_vld,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              unlock,
    input  logic              clr_faults,
    input  logic              mask_in,
    input  logic              mask_pg,
    input  logic              mask_out,
    input  logic              alert_pin_en,
    input  logic              pg_pin_en,
    output logic [WORD_W-1:0] thr_word,
    output logic              out_en,
    output logic              alert_n,
    output logic              pgood,
    output logic [7:0]        st_byte,
    output logic [7:0]        st_word_hi,
    output logic [7:0]        st_out,
    output logic [7:0]        st_in,
    output logic [7:0]        st_mfr
);
    logic [CODE_W-1:0] code;
    logic [VW-1:0]     rise_mv, fall_mv;
    logic              trip, hit;
    flag_t             flags;
    logic              any_flag, src_open;

    ovp_thresh #(
        .CODE_W(CODE_W), .VW(VW), .BASE_MV(BASE_MV),
        .STEP_MV(STEP_MV), .HYST_MV(HYST_MV), .RST_CODE(RST_CODE)
    ) u_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .unlock(unlock),
        .wr_code(wr_data[CODE_W-1:0]), .code_o(code),
        .rise_mv(rise_mv), .fall_mv(fall_mv)
    );

    ovp_detect #(.VW(VW)) u_det (
        .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .vin_vld(vin_vld),
        .rise_mv(rise_mv), .fall_mv(fall_mv), .trip_o(trip), .hit_o(hit)
    );

    ovp_flags u_flg (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr_faults), .flags_o(flags)
    );

    always_comb begin
        thr_word = '0;
        thr_word[CODE_W-1:0] = code;

        out_en   = ~trip;
        pgood    = ~(pg_pin_en & trip);

        any_flag = |flags;
        src_open = ~mask_in | ~mask_pg | ~mask_out;
        alert_n  = ~(any_flag & alert_pin_en & src_open);

        st_byte       = '0;
        st_byte[6]    = flags.sw_off;
        st_byte[0]    = flags.other;

        st_word_hi    = '0;
        st_word_hi[7] = flags.out_uvw;
        st_word_hi[5] = flags.in_ov;
        st_word_hi[3] = flags.pg_bad;
        st_word_hi[0] = flags.other;

        st_out        = '0;
        st_out[5]     = flags.out_uvw;

        st_in         = '0;
        st_in[7]      = flags.in_ov;

        st_mfr        = '0;
        st_mfr[3]     = flags.pg_bad;
    end

endmodule

// File: rtl/ovp_supervisor_chk.sv
module ovp_supervisor_chk #(
    parameter int VW      = 16,
    parameter int WORD_W  = 16,
    parameter int BASE_MV = 2960,
    parameter int STEP_MV = 984
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VW-1:0]     vin_mv,
    input logic              vin_vld,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              unlock,
    input logic              clr_faults,
    input logic              alert_pin_en,
    input logic              pg_pin_en,
    input logic [WORD_W-1:0] thr_word,
    input logic              out_en,
    input logic              alert_n,
    input logic              pgood,
    input logic [7:0]        st_in
);
    int rise_chk;
    assign rise_chk = BASE_MV + int'(thr_word[3:0]) * STEP_MV;

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock) |=> $stable(thr_word));

    // R2
    unlocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlock) |=> (thr_word == {{(WORD_W-4){1'b0}}, $past(wr_data[3:0])}));

    // R4
    trip_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vin_vld && (int'(vin_mv) > rise_chk)) |=> !out_en);

    // R6
    idle_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_vld |=> $stable(out_en));

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_in != 8'h00 && !clr_faults) |=> (st_in == $past(st_in)));

    // R10
    alert_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> alert_pin_en);

    // R11
    pg_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood |-> (pg_pin_en && !out_en));

endmodule

bind ovp_supervisor ovp_supervisor_chk #(
    .VW(VW), .WORD_W(WORD_W), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .vin_vld(vin_vld),
    .wr_en(wr_en), .wr_data(wr_data), .unlock(unlock), .clr_faults(clr_faults),
    .alert_pin_en(alert_pin_en), .pg_pin_en(pg_pin_en), .thr_word(thr_word),
    .out_en(out_en), .alert_n(alert_n), .pgood(pgood), .st_in(st_in)
);

// File: tb/sim_ovp_supervisor.sv
`timescale 1ns/1ps
module sim_ovp_supervisor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] vin_mv;
    logic        vin_vld, wr_en, unlock, clr_faults;
    logic [15:0] wr_data;
    logic        mask_in, mask_pg, mask_out, alert_pin_en, pg_pin_en;
    logic [15:0] thr_word;
    logic        out_en, alert_n, pgood;
    logic [7:0]  st_byte, st_word_hi, st_out, st_in, st_mfr;

    int  errs = 0, checks = 0;
    int  m_code;
    bit  m_trip, m_flag, done = 0;

    always #5 clk = ~clk;

    ovp_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .vin_vld(vin_vld),
        .wr_en(wr_en), .wr_data(wr_data), .unlock(unlock), .clr_faults(clr_faults),
        .mask_in(mask_in), .mask_pg(mask_pg), .mask_out(mask_out),
        .alert_pin_en(alert_pin_en), .pg_pin_en(pg_pin_en),
        .thr_word(thr_word), .out_en(out_en), .alert_n(alert_n), .pgood(pgood),
        .st_byte(st_byte), .st_word_hi(st_word_hi), .st_out(st_out),
        .st_in(st_in), .st_mfr(st_mfr)
    );

    function automatic int rise_of(int c);
        return 2960 + c * 984;
    endfunction

    function automatic bit exp_alert_n();
        return !(m_flag && alert_pin_en && (!mask_in || !mask_pg || !mask_out));
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 thr_word", thr_word, m_code);
        chk("R4 R5 out_en", out_en, !m_trip);
        chk("R7 st_byte", st_byte, m_flag ? 'h41 : 0);
        chk("R7 st_word_hi", st_word_hi, m_flag ? 'hA9 : 0);
        chk("R7 st_out", st_out, m_flag ? 'h20 : 0);
        chk("R7 st_in", st_in, m_flag ? 'h80 : 0);
        chk("R7 st_mfr", st_mfr, m_flag ? 'h08 : 0);
        chk("R10 alert_n", alert_n, exp_alert_n());
        chk("R11 pgood", pgood, !(pg_pin_en && m_trip));
    endtask

    // one clock: reference model update at the edge, compare at the falling edge
    task automatic step();
        int  r, f;
        bit  nt;
        @(posedge clk);
        r  = rise_of(m_code);
        f  = r - 250;
        nt = m_trip;
        if (vin_vld) begin
            if (int'(vin_mv) > r) nt = 1;
            else if (int'(vin_mv) < f) nt = 0;
        end
        if (vin_vld && nt) m_flag = 1;
        else if (clr_faults) m_flag = 0;
        m_trip = nt;
        if (wr_en && unlock) m_code = int'(wr_data[3:0]);
        @(negedge clk);
        compare_all();
    endtask

    task automatic sample(int mv);
        vin_mv = 16'(mv); vin_vld = 1; step(); vin_vld = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; vin_mv = 0; vin_vld = 0; wr_en = 0; wr_data = 0; unlock = 0;
        clr_faults = 0; mask_in = 0; mask_pg = 0; mask_out = 0;
        alert_pin_en = 1; pg_pin_en = 1;
        m_code = 14; m_trip = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 thr_word", thr_word, 'h000E);
        chk("R1 out_en", out_en, 1);
        chk("R1 alert_n", alert_n, 1);
        chk("R1 pgood", pgood, 1);
        chk("R1 flags", {st_byte, st_word_hi, st_out, st_in, st_mfr}, 0);
        rst_n = 1;
        step();

        // R3 locked write ignored
        wr_en = 1; wr_data = 16'hFFF3; unlock = 0; step(); wr_en = 0; step();
        chk("R3 locked write", thr_word, 'h000E);

        // R2 unlocked write, upper bits dropped
        wr_en = 1; wr_data = 16'hABC0; unlock = 1; step(); wr_en = 0; unlock = 0; step();
        chk("R2 code zero", thr_word, 'h0000);

        // R4 equality does not trip, one above trips
        sample(2960); chk("R4 equal", out_en, 1);
        sample(2961); chk("R4 above", out_en, 0);
        chk("R7 in status", st_in, 'h80);
        // R6 invalid sample ignored
        vin_mv = 0; step(); chk("R6 invalid", out_en, 0);
        // R5 hysteresis band
        sample(2710); chk("R5 at fall", out_en, 0);
        // R9 clear while tripped: set wins
        clr_faults = 1; sample(2800); clr_faults = 0;
        chk("R9 set wins", st_byte, 'h41);
        sample(2709); chk("R5 release", out_en, 1);
        // R8 sticky after recovery
        sample(1000); chk("R8 sticky", st_word_hi, 'hA9);
        chk("R10 alert held", alert_n, 0);
        // R10 all masked suppresses
        mask_in = 1; mask_pg = 1; mask_out = 1; step();
        chk("R10 masked", alert_n, 1);
        mask_pg = 0; alert_pin_en = 0; step();
        chk("R10 pin off", alert_n, 1);
        alert_pin_en = 1; mask_in = 0; mask_out = 0;
        clr_faults = 1; step(); clr_faults = 0;
        chk("R8 cleared", st_mfr, 0);
        // R11 pin not configured
        pg_pin_en = 0; sample(20000);
        chk("R11 unconfigured", pgood, 1);
        pg_pin_en = 1; step();
        chk("R11 configured", pgood, 0);

        // random sweeps near the thresholds
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = rise_of(m_code);
            vin_mv       = 16'(r - 500 + int'($urandom_range(0, 1000)));
            vin_vld      = ($urandom_range(0, 9) < 7);
            wr_en        = ($urandom_range(0, 19) == 0);
            unlock       = $urandom_range(0, 1);
            wr_data      = 16'($urandom);
            clr_faults   = ($urandom_range(0, 29) == 0);
            if (i % 40 == 0) begin
                mask_in      = $urandom_range(0, 1);
                mask_pg      = $urandom_range(0, 1);
                mask_out     = $urandom_range(0, 1);
                alert_pin_en = $urandom_range(0, 1);
                pg_pin_en    = $urandom_range(0, 1);
            end
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule